// File: doc/BRIEF.md
# Power-of-two spatial partition controller

This block divides a shared pool of fabric rows among several cores. The pool is cut into a number of equal partitions, and that number is always a power of two: the smallest one that covers the cores currently using the fabric. Each active core owns one partition. The core's partition index and the partition size drive the row input multiplexers, which are outside this block. A core asks to start a fabric function with `core_req`. The controller grants the request when the core owns a partition and that partition has no function in flight. The fabric reports the end of a function with a per-partition `part_done` pulse.

Every core has an idle counter. The counter is cleared while the core requests or its partition is busy, and it counts up on every other cycle. A core whose counter has reached the idle limit is inactive. An inactive core becomes active again as soon as it requests.

A change in the active set can move the sharer count into a different power-of-two bucket, or leave an active core without a partition. When that happens the controller stops granting and waits until every in-flight function has completed. It then recomputes the partition count and hands out indices again in ascending core order, so the rows of a core that has left go to the remaining sharers.

Top module: `fabric_share_ctrl`

## Requirements
- R1: After reset `part_count` is 1, `part_rows` equals NUM_ROWS, `core_assigned` is all zero, `reconfig` is 0, and every core is inactive.
- R2: `part_count` is 2 to the power L, where L is the current partition log. `part_rows` equals NUM_ROWS divided by `part_count`. After a repartition, L is the smallest value for which 2^L is at least the number of active cores, with a minimum of 0.
- R3: A core's idle counter clears on any cycle in which the core requests or its own partition has a function in flight. On every other cycle it increments, saturating at IDLE_LIMIT (1000 by default). The core is inactive once the counter equals IDLE_LIMIT. Consequently a lone core that is silent for 1000 cycles after its last request causes `reconfig` to rise on the following edge.
- R4: If the active set changes but the power-of-two bucket stays the same and every active core still owns a partition, no repartition takes place. `reconfig` stays 0, and an idle core keeps its partition.
- R5: A repartition is needed when the bucket changes, when an active core has no partition, or when no core is active but some core is still assigned. The sequence is run → drain → repartition → run. While draining, the controller stays in drain until no partition has a function in flight, and repartition lasts one cycle. `reconfig` is 1 outside run. No grant is given outside run, nor in a run cycle in which a repartition is needed.
- R6: At repartition, `core_assigned` becomes the active set. Active cores receive partition indices 0, 1, 2, … in ascending core-ID order. Core i's index is the field `core_part[i*IDX_W +: IDX_W]`. Assignments change at no other time.
- R7: In a run cycle with no repartition needed, `core_grant[i]` is 1 exactly when core i requests, is assigned, and its partition has no function in flight. The grant is combinational in the same cycle.
- R8: A grant marks the core's partition as in flight from the next cycle on. Bit p of `part_done` clears partition p. A done bit for a partition that is not in flight has no effect.
- R9: With no active core, after the repartition `part_count` is 1 and no core is assigned. A request in that state gets no grant.
- R10: A request from an inactive core makes it active and starts the drain-and-repartition sequence that gives it a partition, growing the count when the bucket grows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | NUM_CORES | Per-core request to start a fabric function |
| part_done | input | NUM_PARTS | Per-partition completion pulse; bit p clears partition p |
| core_grant | output | NUM_CORES | Per-core grant of this cycle's request |
| core_assigned | output | NUM_CORES | Core owns a partition |
| core_part | output | NUM_CORES*IDX_W | Packed partition index for each core |
| part_count | output | P_LOG+1 | Number of partitions, a power of two |
| part_rows | output | clog2(NUM_ROWS+1) | Rows per partition |
| reconfig | output | 1 | Controller is draining or repartitioning |

## Verification
Two things can fall in the same cycle: a completion pulse on one partition and a grant that starts a new function on another, or a completion of the last in-flight function and a wake-up request that makes a further repartition necessary. The random phases drive requests and completion masks independently on every cycle. The masks include completion bits for partitions that are not busy, and cores join and leave so that drains overlap with fresh requests. A cycle-by-cycle reference model in the bench predicts the grant, the assignment, the count and `reconfig`. Directed checks pin the idle boundary at exactly 1000 cycles and the final index layout.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_REPART = 2'd2
    } fsc_state_e;

    // Smallest r with 2**r >= v (v >= 1).
    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/fsc_idle_counter.sv
module fsc_idle_counter #(
    parameter int IDLE_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    output logic active
);
    localparam int IW = $clog2(IDLE_LIMIT + 1);

    logic [IW-1:0] idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (touch)
            idle_d = '0;
        else if (idle_q < IW'(IDLE_LIMIT))
            idle_d = idle_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= IW'(IDLE_LIMIT);
        else        idle_q <= idle_d;
    end

    assign active = idle_q < IW'(IDLE_LIMIT);

    // R3: counter saturates at the limit
    a_r3_idle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= IW'(IDLE_LIMIT));

    // R3: any touch makes the core active on the next cycle
    a_r3_touch_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> active);

endmodule

// File: rtl/fsc_bucket.sv
module fsc_bucket #(
    parameter int NUM_CORES = 4,
    parameter int P_LOG     = 2,
    parameter int LOG_W     = 2,
    parameter int NA_W      = 3
) (
    input  logic [NUM_CORES-1:0] active,
    output logic [NA_W-1:0]      n_act,
    output logic [LOG_W-1:0]     tgt_log
);
    always_comb begin
        n_act = '0;
        for (int i = 0; i < NUM_CORES; i++)
            n_act = n_act + NA_W'(active[i]);
        tgt_log = LOG_W'(P_LOG);
        for (int k = P_LOG; k >= 0; k--)
            if ((1 << k) >= int'(n_act))
                tgt_log = LOG_W'(k);
    end
endmodule

// File: rtl/fsc_assigner.sv
module fsc_assigner #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_CORES-1:0]       active,
    output logic [NUM_CORES*IDX_W-1:0] idx_flat
);
    always_comb begin
        int cnt;
        cnt = 0;
        idx_flat = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (active[i]) begin
                idx_flat[i*IDX_W +: IDX_W] = IDX_W'(cnt);
                cnt++;
            end
        end
    end
endmodule

// File: rtl/fabric_share_ctrl.sv
module fabric_share_ctrl #(
    parameter  int NUM_CORES  = 4,
    parameter  int NUM_ROWS   = 24,
    parameter  int IDLE_LIMIT = 1000,
    localparam int P_LOG      = fsc_pkg::ceil_log2(NUM_CORES),
    localparam int NUM_PARTS  = 1 << P_LOG,
    localparam int IDX_W      = (P_LOG > 0) ? P_LOG : 1,
    localparam int LOG_W      = (P_LOG > 0) ? $clog2(P_LOG + 1) : 1,
    localparam int CNT_W      = P_LOG + 1,
    localparam int ROW_W      = $clog2(NUM_ROWS + 1),
    localparam int NA_W       = $clog2(NUM_CORES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       core_req,
    input  logic [NUM_PARTS-1:0]       part_done,
    output logic [NUM_CORES-1:0]       core_grant,
    output logic [NUM_CORES-1:0]       core_assigned,
    output logic [NUM_CORES*IDX_W-1:0] core_part,
    output logic [CNT_W-1:0]           part_count,
    output logic [ROW_W-1:0]           part_rows,
    output logic                       reconfig
);
    import fsc_pkg::*;

    typedef struct packed {
        fsc_state_e                 st;
        logic [NUM_PARTS-1:0]       infl;
        logic [NUM_CORES-1:0]       asg;
        logic [NUM_CORES*IDX_W-1:0] part;
        logic [LOG_W-1:0]           lg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]           pidx [NUM_CORES];
    logic [NUM_CORES-1:0]       touch;
    logic [NUM_CORES-1:0]       active;
    logic [NA_W-1:0]            n_act;
    logic [LOG_W-1:0]           tgt_log;
    logic [NUM_CORES*IDX_W-1:0] new_idx;
    logic [NUM_CORES-1:0]       grant;
    logic                       need;

    // Partition ownership and idle touch per core
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            pidx[i]  = ctl_q.part[i*IDX_W +: IDX_W];
            touch[i] = core_req[i] | (ctl_q.asg[i] & ctl_q.infl[pidx[i]]);
        end
    end

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_idle
        fsc_idle_counter #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
            .clk    (clk),
            .rst_n  (rst_n),
            .touch  (touch[gi]),
            .active (active[gi])
        );
    end

    fsc_bucket #(
        .NUM_CORES (NUM_CORES),
        .P_LOG     (P_LOG),
        .LOG_W     (LOG_W),
        .NA_W      (NA_W)
    ) u_bucket (
        .active  (active),
        .n_act   (n_act),
        .tgt_log (tgt_log)
    );

    fsc_assigner #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W)
    ) u_assign (
        .active   (active),
        .idx_flat (new_idx)
    );

    // Next-state logic
    always_comb begin
        ctl_d = ctl_q;
        grant = '0;
        need  = (tgt_log != ctl_q.lg)
              || ((active & ~ctl_q.asg) != '0)
              || ((n_act == '0) && (ctl_q.asg != '0));
        ctl_d.infl = ctl_q.infl & ~part_done;
        case (ctl_q.st)
            ST_RUN: begin
                if (need) begin
                    ctl_d.st = ST_DRAIN;
                end else begin
                    for (int i = 0; i < NUM_CORES; i++) begin
                        if (core_req[i] && ctl_q.asg[i] && !ctl_q.infl[pidx[i]]) begin
                            grant[i] = 1'b1;
                            ctl_d.infl[pidx[i]] = 1'b1;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (ctl_q.infl == '0)
                    ctl_d.st = ST_REPART;
            end
            ST_REPART: begin
                ctl_d.st   = ST_RUN;
                ctl_d.asg  = active;
                ctl_d.part = new_idx;
                ctl_d.lg   = tgt_log;
            end
            default: ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_RUN;
            ctl_q.infl <= '0;
            ctl_q.asg  <= '0;
            ctl_q.part <= '0;
            ctl_q.lg   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign core_grant    = grant;
    assign core_assigned = ctl_q.asg;
    assign core_part     = ctl_q.part;
    assign part_count    = CNT_W'(1) << ctl_q.lg;
    assign part_rows     = ROW_W'(NUM_ROWS) >> ctl_q.lg;
    assign reconfig      = (ctl_q.st != ST_RUN);

    // R5: nothing is granted while draining or repartitioning
    a_r5_no_grant_reconfig: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |-> (core_grant == '0));

    // R5: no new in-flight partition appears during drain
    a_r5_drain_no_new: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_DRAIN) |=> ((ctl_q.infl & ~$past(ctl_q.infl)) == '0));

    // R7: only assigned cores are granted
    a_r7_grant_assigned: assert property (@(posedge clk) disable iff (!rst_n)
        (core_grant & ~core_assigned) == '0);

    // R2: partition count is a power of two
    a_r2_count_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(part_count) == 1);

    // R6: mapping changes only out of the repartition state
    a_r6_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_REPART) |=> ($stable(core_part) && $stable(core_assigned)));

    // R9: an empty pool ends with one partition and no owner
    a_r9_empty_pool: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_REPART && n_act == '0) |=> (core_assigned == '0 && part_count == CNT_W'(1)));

endmodule

// File: tb/tb_fabric_share_ctrl.sv
module tb_fabric_share_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int NR  = 24;
    localparam int LIM = 1000;
    localparam int IW  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] done = '0;
    logic [3:0] grant, asg;
    logic [7:0] part;
    logic [2:0] cnt;
    logic [4:0] rows;
    logic       reconfig;

    fabric_share_ctrl #(.NUM_CORES(NC), .NUM_ROWS(NR), .IDLE_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .core_req(req), .part_done(done),
        .core_grant(grant), .core_assigned(asg), .core_part(part),
        .part_count(cnt), .part_rows(rows), .reconfig(reconfig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int         m_idle [NC];
    int         m_st;
    logic [3:0] m_infl, m_asg;
    int         m_part [NC];
    int         m_lg;
    int         nchk = 0, nerr = 0, rc_seen = 0;
    bit         finished = 0;

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic int tgt_of(input int n);
        int t;
        t = 0;
        while ((1 << t) < n) t++;
        return t;
    endfunction

    task automatic step(input logic [3:0] r, input logic [3:0] d);
        logic [3:0] act, eg, infl_n, asg_n;
        int n, tgt, st_n, lg_n, k;
        bit need;
        int idle_n [NC];
        int part_n [NC];
        @(negedge clk);
        req = r; done = d;
        #1;
        for (int i = 0; i < NC; i++) act[i] = (m_idle[i] < LIM);
        n = $countones(act);
        tgt = tgt_of(n);
        need = (tgt != m_lg) || ((act & ~m_asg) != 0) || (n == 0 && m_asg != 0);
        eg = '0;
        if (m_st == 0 && !need)
            for (int i = 0; i < NC; i++)
                if (r[i] && m_asg[i] && !m_infl[m_part[i]]) eg[i] = 1'b1;
        chk("R7/R8 grant", int'(grant), int'(eg));
        chk("R2 count", int'(cnt), 1 << m_lg);
        chk("R2 rows", int'(rows), NR >> m_lg);
        chk("R6 assigned", int'(asg), int'(m_asg));
        for (int i = 0; i < NC; i++)
            if (m_asg[i]) chk("R6 part", int'(part[i*IW +: IW]), m_part[i]);
        chk("R5 reconfig", int'(reconfig), int'(m_st != 0));
        if (reconfig) rc_seen++;
        infl_n = m_infl & ~d;
        for (int i = 0; i < NC; i++) if (eg[i]) infl_n[m_part[i]] = 1'b1;
        for (int i = 0; i < NC; i++) begin
            if (r[i] || (m_asg[i] && m_infl[m_part[i]])) idle_n[i] = 0;
            else if (m_idle[i] < LIM) idle_n[i] = m_idle[i] + 1;
            else idle_n[i] = m_idle[i];
            part_n[i] = m_part[i];
        end
        st_n = m_st; asg_n = m_asg; lg_n = m_lg;
        case (m_st)
            0: if (need) st_n = 1;
            1: if (m_infl == 0) st_n = 2;
            default: begin
                st_n = 0; asg_n = act; lg_n = tgt; k = 0;
                for (int i = 0; i < NC; i++)
                    if (act[i]) begin part_n[i] = k; k++; end
            end
        endcase
        @(posedge clk);
        m_infl = infl_n; m_st = st_n; m_asg = asg_n; m_lg = lg_n;
        for (int i = 0; i < NC; i++) begin
            m_idle[i] = idle_n[i];
            m_part[i] = part_n[i];
        end
    endtask

    task automatic phase(input logic [3:0] live, input int cycles);
        for (int c = 0; c < cycles; c++)
            step(live & 4'($urandom), 4'($urandom) & 4'($urandom));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NC; i++) begin m_idle[i] = LIM; m_part[i] = 0; end
        m_st = 0; m_infl = '0; m_asg = '0; m_lg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R1: reset state
        chk("R1 count", int'(cnt), 1);
        chk("R1 rows", int'(rows), NR);
        chk("R1 assigned", int'(asg), 0);
        chk("R1 reconfig", int'(reconfig), 0);
        chk("R1 grant", int'(grant), 0);

        // All four sharers
        phase(4'b1111, 300); #1;
        chk("R2 count4", int'(cnt), 4);
        chk("R2 rows6", int'(rows), 6);
        chk("R6 asg all", int'(asg), 15);
        chk("R6 part order", int'(part), 8'b11_10_01_00);

        // Core 3 goes idle: still in the bucket of four
        rc_seen = 0;
        phase(4'b0111, 1200); #1;
        chk("R4 no repartition", rc_seen, 0);
        chk("R4 count kept", int'(cnt), 4);
        chk("R4 idle core keeps rows", int'(asg), 15);

        // Down to two sharers
        phase(4'b0011, 1200); #1;
        chk("R2 count2", int'(cnt), 2);
        chk("R2 rows12", int'(rows), 12);
        chk("R6 asg two", int'(asg), 3);
        chk("R6 idx c1", int'(part[IW +: IW]), 1);

        // One sharer left
        phase(4'b0010, 1200); #1;
        chk("R2 count1", int'(cnt), 1);
        chk("R2 rows24", int'(rows), 24);
        chk("R6 asg one", int'(asg), 2);
        chk("R6 idx c1 zero", int'(part[IW +: IW]), 0);

        // Nobody left
        phase(4'b0000, 1200); #1;
        chk("R9 count", int'(cnt), 1);
        chk("R9 no owner", int'(asg), 0);
        req = 4'b0010; #1;
        chk("R9 grant blocked", int'(grant), 0);

        // Idle boundary: one request, then exactly 1000 silent cycles
        step(4'b0010, 4'b1111);
        for (int c = 0; c < 1000; c++) step(4'b0000, 4'b1111);
        #1;
        chk("R3 still owner at 1000", int'(asg), 2);
        chk("R3 no reconfig yet", int'(reconfig), 0);
        step(4'b0000, 4'b1111); #1;
        chk("R3 reconfig after limit", int'(reconfig), 1);
        for (int c = 0; c < 10; c++) step(4'b0000, 4'b1111);
        #1;
        chk("R9 released", int'(asg), 0);

        // Three cores wake up
        phase(4'b1101, 300); #1;
        chk("R10 count grows", int'(cnt), 4);
        chk("R10 asg", int'(asg), 4'b1101);
        chk("R6 idx c0", int'(part[0 +: IW]), 0);
        chk("R6 idx c2", int'(part[2*IW +: IW]), 1);
        chk("R6 idx c3", int'(part[3*IW +: IW]), 2);

        finished = 1;
        summary();
    end
endmodule